// File: doc/BRIEF.md
# I2C SDA Output Delay Unit

This block sits between the transmit bit of a serial engine and the open-drain SDA pad driver. In I2C operation it stops the SDA drive from changing until SCL has been sampled low for a programmable number of system clock cycles. This gives the data line hold time after the clock edge without relying on pad timing. The output is an open-drain drive level: 1 releases the line and 0 pulls it low.

The delay is controlled by a digital-select flag and a 3-bit delay code. The unit keeps an effective copy of the code and reports it back. When the select flag is low, that copy is forced to 000. An effective code of 000 picks the analog path. This model treats the analog path as a zero-wait pass: SDA may follow the transmit bit from the first cycle in which SCL is seen low. A nonzero effective code waits code+1 cycles. When I2C operation is disabled, the transmit bit goes straight to the registered output whatever SCL does.

Top module: `sda_delay_unit`

## Requirements
- R1: Reset (synchronous, active high) sets the SDA drive to 1 (released) and the reported delay code to 000.
- R2: One clock after any cycle, the reported delay code equals the delay-code input if the select flag was 1 in that cycle, and 000 if the flag was 0.
- R3: With I2C mode off, the SDA drive one clock later equals the transmit bit, whatever the SCL level.
- R4: With I2C mode on, the SDA drive never changes after a clock edge at which SCL was sampled high.
- R5: With I2C mode on and a reported code c in the range 001 to 111, let E0 be the first clock edge at which SCL is sampled low. The SDA drive takes the transmit bit at edge E0+c+1 and no earlier, giving a wait of c+1 cycles (2 to 8).
- R6: With I2C mode on and a reported code of 000, the SDA drive takes the transmit bit at edge E0. This holds both when the select flag is 0 and when the select flag is 1 with a code input of 000.
- R7: Once the wait has expired and SCL stays low, the SDA drive follows the transmit bit with one clock of latency.
- R8: If SCL is sampled high before the wait expires, the SDA drive keeps its previous value. The next low period starts a complete new wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| i2c_en | input | 1 | I2C operation enable; 0 selects direct pass of the transmit bit |
| dly_sel | input | 1 | Digital delay select; 0 forces the effective code to 000 |
| dly_code | input | CODE_W | Requested delay code |
| tx_bit | input | 1 | Raw SDA value from the serial engine |
| scl_in | input | 1 | Synchronized SCL level |
| sda_drive | output | 1 | Registered open-drain SDA drive (1 = released) |
| dly_code_fb | output | CODE_W | Effective delay code written back |

## Verification
The bound checker tests the port-level invariants on every cycle. These are the reset values, the forcing and loading of the written-back code, the direct pass when I2C mode is off, and the rule that SDA never moves after an edge with SCL high. Only the bench scenarios can show the cycle counts. They measure the exact edge at which SDA changes for several codes, confirm that the analog path has no wait in both of its selecting conditions, and show that SDA tracks the transmit bit after expiry. They also cover a wait cut short by SCL rising, followed by a full restart.

// File: rtl/sda_dly_pkg.sv
package sda_dly_pkg;

  // Phase of the low-clock window seen by the delay timer
  typedef enum logic [1:0] {
    PH_HOLD = 2'd0,  // SCL high, or first low sample not yet taken
    PH_WAIT = 2'd1,  // counting down the digital wait
    PH_OPEN = 2'd2   // wait over, SDA may follow the transmit bit
  } phase_t;

endpackage

// File: rtl/sda_dly_code.sv
module sda_dly_code #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dsel_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o
);

  logic [CODE_W-1:0] code_q;

  // Effective code: cleared whenever digital select is off
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
    end else if (dsel_i) begin
      code_q <= code_i;
    end else begin
      code_q <= '0;
    end
  end

  assign code_o = code_q;

endmodule

// File: rtl/sda_dly_timer.sv
module sda_dly_timer
  import sda_dly_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              scl_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              load_o
);

  phase_t            phase_q;
  logic [CODE_W-1:0] cnt_q;
  logic              analog;

  assign analog = (code_i == '0);

  // Output update permission for the current cycle
  always_comb begin
    load_o = 1'b0;
    if (en_i && !scl_i) begin
      case (phase_q)
        PH_HOLD: load_o = analog;
        PH_WAIT: load_o = (cnt_q == '0);
        PH_OPEN: load_o = 1'b1;
        default: load_o = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_HOLD;
      cnt_q   <= '0;
    end else if (!en_i || scl_i) begin
      // High clock (or bypass) aborts any wait; pending bit stays at tx input
      phase_q <= PH_HOLD;
    end else begin
      case (phase_q)
        PH_HOLD: begin
          if (analog) begin
            phase_q <= PH_OPEN;
          end else begin
            phase_q <= PH_WAIT;
            cnt_q   <= code_i;
          end
        end
        PH_WAIT: begin
          if (cnt_q == '0) begin
            phase_q <= PH_OPEN;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_OPEN: phase_q <= PH_OPEN;
        default: phase_q <= PH_HOLD;
      endcase
    end
  end

endmodule

// File: rtl/sda_dly_out.sv
module sda_dly_out (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic load_i,
  input  logic tx_i,
  output logic sda_o
);

  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_q <= 1'b1;
    end else if (!en_i || load_i) begin
      sda_q <= tx_i;
    end
  end

  assign sda_o = sda_q;

endmodule

// File: rtl/sda_delay_unit.sv
module sda_delay_unit #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              i2c_en,
  input  logic              dly_sel,
  input  logic [CODE_W-1:0] dly_code,
  input  logic              tx_bit,
  input  logic              scl_in,
  output logic              sda_drive,
  output logic [CODE_W-1:0] dly_code_fb
);

  logic [CODE_W-1:0] code_eff;
  logic              load;

  sda_dly_code #(.CODE_W(CODE_W)) u_code (
    .clk    (clk),
    .rst    (rst),
    .dsel_i (dly_sel),
    .code_i (dly_code),
    .code_o (code_eff)
  );

  sda_dly_timer #(.CODE_W(CODE_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .en_i   (i2c_en),
    .scl_i  (scl_in),
    .code_i (code_eff),
    .load_o (load)
  );

  sda_dly_out u_out (
    .clk    (clk),
    .rst    (rst),
    .en_i   (i2c_en),
    .load_i (load),
    .tx_i   (tx_bit),
    .sda_o  (sda_drive)
  );

  assign dly_code_fb = code_eff;

endmodule

// File: rtl/sda_dly_checker.sv
module sda_dly_checker #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              i2c_en,
  input logic              dly_sel,
  input logic [CODE_W-1:0] dly_code,
  input logic              tx_bit,
  input logic              scl_in,
  input logic              sda_drive,
  input logic [CODE_W-1:0] dly_code_fb
);

  assert_reset_vals_R1: assert property (@(posedge clk)
    $past(rst) |-> (sda_drive && dly_code_fb == '0));

  assert_code_forced_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!dly_sel)) |-> (dly_code_fb == '0));

  assert_code_loaded_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(dly_sel)) |-> (dly_code_fb == $past(dly_code)));

  assert_bypass_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!i2c_en)) |-> (sda_drive == $past(tx_bit)));

  assert_hold_scl_high_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(i2c_en) && $past(scl_in)) |-> $stable(sda_drive));

endmodule

bind sda_delay_unit sda_dly_checker #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .i2c_en      (i2c_en),
  .dly_sel     (dly_sel),
  .dly_code    (dly_code),
  .tx_bit      (tx_bit),
  .scl_in      (scl_in),
  .sda_drive   (sda_drive),
  .dly_code_fb (dly_code_fb)
);

// File: tb/sda_delay_unit_test.sv
`timescale 1ns/1ps
module sda_delay_unit_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       i2c_en;
  logic       dly_sel;
  logic [2:0] dly_code;
  logic       tx_bit;
  logic       scl_in;
  logic       sda_drive;
  logic [2:0] dly_code_fb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sda_delay_unit #(.CODE_W(3)) uut (
    .clk(clk), .rst(rst), .i2c_en(i2c_en), .dly_sel(dly_sel),
    .dly_code(dly_code), .tx_bit(tx_bit), .scl_in(scl_in),
    .sda_drive(sda_drive), .dly_code_fb(dly_code_fb)
  );

  // {select, code, expected wait in edges after E0}
  localparam logic [7:0] VEC [6] = '{
    {1'b1, 3'd0, 4'd0},   // R6 analog by zero code
    {1'b0, 3'd5, 4'd0},   // R6 analog by cleared select
    {1'b1, 3'd1, 4'd2},   // R5 shortest digital wait
    {1'b1, 3'd3, 4'd4},
    {1'b1, 3'd4, 4'd5},
    {1'b1, 3'd7, 4'd8}    // R5 longest digital wait
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drop SCL and count edges after E0 until SDA changes (-1 if never)
  task automatic measure(output int k);
    logic old;
    old = sda_drive;
    scl_in = 1'b0;
    k = -1;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (sda_drive != old) begin
        k = i;
        break;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int k;
    logic held;
    rst = 1'b1; i2c_en = 1'b0; dly_sel = 1'b0; dly_code = 3'd0;
    tx_bit = 1'b0; scl_in = 1'b1;
    cyc(3);
    chk(sda_drive == 1'b1, "R1 sda after reset", int'(sda_drive), 1);
    chk(dly_code_fb == 3'd0, "R1 code after reset", int'(dly_code_fb), 0);
    rst = 1'b0;

    // R3: bypass ignores SCL level
    i2c_en = 1'b0; tx_bit = 1'b0; scl_in = 1'b1;
    cyc(1);
    chk(sda_drive == 1'b0, "R3 bypass scl high", int'(sda_drive), 0);
    tx_bit = 1'b1; scl_in = 1'b0;
    cyc(1);
    chk(sda_drive == 1'b1, "R3 bypass scl low", int'(sda_drive), 1);

    // Table walk: R2, R4, R5, R6, R7
    for (int v = 0; v < 6; v++) begin
      i2c_en = 1'b1; scl_in = 1'b1;
      dly_sel = VEC[v][7]; dly_code = VEC[v][6:4];
      cyc(2);
      chk(dly_code_fb == (VEC[v][7] ? VEC[v][6:4] : 3'd0), "R2 code feedback",
          int'(dly_code_fb), int'(VEC[v][7] ? VEC[v][6:4] : 3'd0));
      held = sda_drive;
      tx_bit = ~sda_drive;
      cyc(3);
      chk(sda_drive == held, "R4 held while scl high", int'(sda_drive), int'(held));
      measure(k);
      chk(k == int'(VEC[v][3:0]), VEC[v][3:0] == 0 ? "R6 analog wait" : "R5 digital wait",
          k, int'(VEC[v][3:0]));
      tx_bit = ~tx_bit;
      cyc(1);
      chk(sda_drive == tx_bit, "R7 follow after expiry", int'(sda_drive), int'(tx_bit));
    end

    // R8: SCL rises mid-wait, then a full restart
    dly_sel = 1'b1; dly_code = 3'd7; scl_in = 1'b1;
    cyc(2);
    held = sda_drive;
    tx_bit = ~sda_drive;
    scl_in = 1'b0;
    cyc(3);
    scl_in = 1'b1;
    cyc(1);
    chk(sda_drive == held, "R8 aborted wait holds", int'(sda_drive), int'(held));
    cyc(3);
    chk(sda_drive == held, "R8 still held high", int'(sda_drive), int'(held));
    measure(k);
    chk(k == 8, "R8 full restart", k, 8);

    // R1: reset in the middle of operation
    scl_in = 1'b1; tx_bit = 1'b0;
    cyc(1);
    scl_in = 1'b0;
    cyc(10);
    chk(sda_drive == 1'b0, "R7 driven low before reset", int'(sda_drive), 0);
    rst = 1'b1;
    cyc(1);
    chk(sda_drive == 1'b1, "R1 mid-run reset sda", int'(sda_drive), 1);
    chk(dly_code_fb == 3'd0, "R1 mid-run reset code", int'(dly_code_fb), 0);
    rst = 1'b0;
    cyc(2);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule